// File: doc/BRIEF.md
# SPI Page-Size Configuration Command Decoder

This block is the slave-side control logic of a serial flash device that watches an SPI-style link for a single one-time-programmable configuration command. The command selects the binary page size. While the select line is held low, the block gathers serial bits into bytes. It compares the bytes against a fixed four-byte opcode sequence. When the whole sequence has arrived with nothing after it, the command is committed at the moment the select line is released. A self-timed programming cycle then runs for a parameterised number of clock cycles, and the status byte reports busy for that time.

At the end of the cycle a nonvolatile flag is set, and that flag can never be cleared. The active page size does not change straight away. It moves from 528 to 512 bytes only when the power-on reset input is next pulsed, and that input stands in for a power cycle. If the power-on reset arrives while the cycle is still running, the cycle is abandoned and the flag stays clear.

A status-read opcode returns the live status byte on the serial output. All serial inputs are synchronised into the system clock domain, and their edges are detected there.

The control state machine has these states:
- `ST_IDLE`: the select line is inactive.
- `ST_WAIT_OP`: select is active and no byte has arrived yet.
- `ST_GOT1`, `ST_GOT2`, `ST_GOT3`: that many sequence bytes have matched.
- `ST_ARMED`: all four bytes have matched.
- `ST_STATUS`: the status byte is being shifted out.
- `ST_DISCARD`: the rest of the transfer is ignored.

Its transitions are:
- Select falls: `ST_IDLE` to `ST_WAIT_OP`.
- First byte 3Dh while accepting: `ST_WAIT_OP` to `ST_GOT1`.
- First byte D7h: `ST_WAIT_OP` to `ST_STATUS`.
- Any other first byte: `ST_WAIT_OP` to `ST_DISCARD`.
- 2Ah, 80h, A6h in turn: `ST_GOT1` to `ST_GOT2` to `ST_GOT3` to `ST_ARMED`.
- Any byte that does not match: `ST_GOTn` to `ST_DISCARD`.
- Any byte in `ST_ARMED`: to `ST_DISCARD`.
- Select rises: every state goes to `ST_IDLE`. If this happens from `ST_ARMED` with no partial byte pending, it emits the programming start.

Top module: `pgsz_cfg_decoder`

## Requirements
- R1: Serial data is sampled on the rising serial clock edge while select is low, most significant bit first (SPI mode 0); a new output bit is presented after each falling serial clock edge.
- R2: The configuration command is recognised only as the exact byte order 3Dh, 2Ah, 80h, A6h received within one select-low period; a wrong byte, a wrong order or bit-reversed bytes is rejected.
- R3: Programming begins only when select rises with exactly four whole bytes received; fewer bytes, a fifth byte, or a rise after a partial byte aborts with no busy period and no flag change.
- R4: A programming cycle keeps the status byte's bit 7 at 0 (busy) for exactly PROG_CYCLES clock cycles, starting three clock cycles after select rises, and bit 7 is 1 (ready) otherwise.
- R5: A configuration command received while busy, or after the flag is already set, is ignored and starts no cycle; status reads still work while busy.
- R6: Once set, the configuration flag stays set across any number of power-on resets and commands.
- R7: `page_size` reads 528 while no programmed flag has been captured; it reads 512 only after a power-on reset that follows a completed cycle, and it never changes outside a power-on reset.
- R8: Bit 0 of the status byte is 1 exactly when the configuration flag is set. Bits 6 to 1 read 0.
- R9: A power-on reset during the programming cycle ends busy at once and leaves the flag clear, so the command can be issued again.
- R10: After opcode D7h, `spi_miso` shifts out the live status byte, most significant bit first. The first bit follows the opcode's last falling edge. The byte repeats until select rises, and `spi_miso` is 0 whenever no status read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are oversampled on it |
| por_n | input | 1 | Active-low power-on reset, synchronous; models a power cycle |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out (status read) |
| status_byte | output | 8 | Bit 7 ready, bit 0 binary page size configured, others 0 |
| page_size | output | 10 | Active page size in bytes: 528 or 512 |

## Verification
The hardest case to reach from the ports is a power-on reset that lands inside the programming cycle. The flag must stay clear, and a later full cycle must still succeed. The bench reaches it by issuing a valid command, reading status back through `spi_miso` while the cycle is still busy, and only then pulsing `por_n`. The bench keeps the default `PROG_CYCLES` small enough that a whole four-byte command fits inside one busy window. That lets it send a second full command in the middle of the cycle. It then checks, on the exact expected cycle, that busy ends without being extended.

// File: rtl/pgsz_pkg.sv
package pgsz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_OP,
        ST_GOT1,
        ST_GOT2,
        ST_GOT3,
        ST_ARMED,
        ST_STATUS,
        ST_DISCARD
    } cmd_state_t;

    localparam int unsigned SEQ_LEN = 4;
    localparam logic [7:0]  OPC_READ_STATUS = 8'hD7;

    localparam int unsigned PAGE_W   = 10;
    localparam logic [PAGE_W-1:0] PAGE_STD = 10'd528;
    localparam logic [PAGE_W-1:0] PAGE_BIN = 10'd512;

    // Expected byte at a given position of the configuration sequence.
    function automatic logic [7:0] seq_byte(input logic [1:0] pos);
        logic [7:0] b;
        unique case (pos)
            2'd0: b = 8'h3D;
            2'd1: b = 8'h2A;
            2'd2: b = 8'h80;
            default: b = 8'hA6;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pgsz_spi_rx.sv
module pgsz_spi_rx #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    output logic       sel_begin,
    output logic       sel_end,
    output logic       sclk_fall,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       partial
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] sclk_s;
    logic [LAST:0] cs_s;
    logic [LAST:0] mosi_s;
    logic          sclk_d;
    logic          cs_d;
    logic [2:0]    bit_cnt;
    logic [6:0]    shreg;

    logic s_sclk;
    logic s_cs_n;
    logic s_mosi;
    logic sclk_rise;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_s <= {sclk_s[LAST-1:0], sclk_i};
            cs_s   <= {cs_s[LAST-1:0], cs_n_i};
            mosi_s <= {mosi_s[LAST-1:0], mosi_i};
            sclk_d <= s_sclk;
            cs_d   <= s_cs_n;
        end
    end

    assign s_sclk = sclk_s[LAST];
    assign s_cs_n = cs_s[LAST];
    assign s_mosi = mosi_s[LAST];

    assign sclk_rise = s_sclk & ~sclk_d & ~s_cs_n;
    assign sclk_fall = ~s_sclk & sclk_d & ~s_cs_n;
    assign sel_begin = ~s_cs_n & cs_d;
    assign sel_end   = s_cs_n & ~cs_d;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (s_cs_n) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg   <= {shreg[5:0], s_mosi};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    assign byte_vld  = sclk_rise & (bit_cnt == 3'd7);
    assign byte_data = {shreg, s_mosi};
    assign partial   = (bit_cnt != 3'd0);

endmodule

// File: rtl/pgsz_cmd_fsm.sv
module pgsz_cmd_fsm
    import pgsz_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sel_begin,
    input  logic       sel_end,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       partial,
    input  logic       busy,
    input  logic       otp_set,
    output logic       prog_start,
    output logic       status_mode
);

    cmd_state_t state;
    cmd_state_t nxt;
    logic       accepting;

    assign accepting = ~busy & ~otp_set;

    always_ff @(posedge clk) begin
        if (!por_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (sel_end) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sel_begin) nxt = ST_WAIT_OP;
                end
                ST_WAIT_OP: begin
                    if (byte_vld) begin
                        if (byte_data == OPC_READ_STATUS)
                            nxt = ST_STATUS;
                        else if (byte_data == seq_byte(2'd0) && accepting)
                            nxt = ST_GOT1;
                        else
                            nxt = ST_DISCARD;
                    end
                end
                ST_GOT1: begin
                    if (byte_vld)
                        nxt = (byte_data == seq_byte(2'd1)) ? ST_GOT2 : ST_DISCARD;
                end
                ST_GOT2: begin
                    if (byte_vld)
                        nxt = (byte_data == seq_byte(2'd2)) ? ST_GOT3 : ST_DISCARD;
                end
                ST_GOT3: begin
                    if (byte_vld)
                        nxt = (byte_data == seq_byte(2'd3)) ? ST_ARMED : ST_DISCARD;
                end
                ST_ARMED: begin
                    if (byte_vld) nxt = ST_DISCARD;
                end
                ST_STATUS:  nxt = ST_STATUS;
                ST_DISCARD: nxt = ST_DISCARD;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        prog_start  = sel_end && (state == ST_ARMED) && !partial;
        status_mode = (state == ST_STATUS);
    end

endmodule

// File: rtl/pgsz_prog_timer.sv
module pgsz_prog_timer #(
    parameter int unsigned PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!por_n)
            cnt <= '0;
        else if (start && cnt == '0)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/pgsz_otp_cfg.sv
module pgsz_otp_cfg (
    input  logic clk,
    input  logic por_n,
    input  logic prog_done,
    output logic otp_set,
    output logic bin_active
);

    // Nonvolatile cell: holds its value through power-on reset.
    logic otp_q = 1'b0;
    logic act_q;

    always_ff @(posedge clk) begin
        if (prog_done && por_n) otp_q <= 1'b1;
    end

    // Staged activation: the page size is captured only during power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) act_q <= otp_q;
    end

    assign otp_set    = otp_q;
    assign bin_active = act_q;

endmodule

// File: rtl/pgsz_cfg_decoder.sv
module pgsz_cfg_decoder
    import pgsz_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [7:0]        status_byte,
    output logic [PAGE_W-1:0] page_size
);

    logic       sel_begin;
    logic       sel_end;
    logic       sclk_fall;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       partial;
    logic       prog_start;
    logic       status_mode;
    logic       prog_busy;
    logic       prog_done;
    logic       otp_set;
    logic       bin_active;
    logic       miso_q;
    logic [2:0] out_idx;

    pgsz_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .por_n     (por_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sel_begin (sel_begin),
        .sel_end   (sel_end),
        .sclk_fall (sclk_fall),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .partial   (partial)
    );

    pgsz_cmd_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .sel_begin   (sel_begin),
        .sel_end     (sel_end),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .partial     (partial),
        .busy        (prog_busy),
        .otp_set     (otp_set),
        .prog_start  (prog_start),
        .status_mode (status_mode)
    );

    pgsz_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .start (prog_start),
        .busy  (prog_busy),
        .done  (prog_done)
    );

    pgsz_otp_cfg u_otp (
        .clk        (clk),
        .por_n      (por_n),
        .prog_done  (prog_done),
        .otp_set    (otp_set),
        .bin_active (bin_active)
    );

    assign status_byte = {~prog_busy, 6'b000000, otp_set};
    assign page_size   = bin_active ? PAGE_BIN : PAGE_STD;

    always_ff @(posedge clk) begin
        if (!por_n || !status_mode) begin
            miso_q  <= 1'b0;
            out_idx <= '0;
        end else if (sclk_fall) begin
            miso_q  <= status_byte[3'd7 - out_idx];
            out_idx <= out_idx + 3'd1;
        end
    end

    assign spi_miso = miso_q;

endmodule

// File: rtl/pgsz_cfg_decoder_chk.sv
module pgsz_cfg_decoder_chk #(
    parameter int unsigned PROG_CYCLES = 1000
) (
    input logic       clk,
    input logic       por_n,
    input logic       busy,
    input logic       nv_flag,
    input logic       cs_end,
    input logic [9:0] page_size
);

    localparam int unsigned RUN_W = $clog2(PROG_CYCLES + 2);
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!por_n || !busy) run_len <= '0;
        else                 run_len <= run_len + RUN_W'(1);
    end

    // R6: the one-time flag never returns to zero
    p_otp_sticky_r6: assert property (@(posedge clk) nv_flag |=> nv_flag);

    // R4: the flag can only appear at the end of a busy period
    p_set_after_busy_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(nv_flag) |-> $past(busy));

    // R3: a busy period only starts right after select is released
    p_start_on_release_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(cs_end));

    // R9: power-on reset ends the programming cycle
    p_por_stops_cycle_r9: assert property (@(posedge clk) !por_n |=> !busy);

    // R7: the page size moves only under power-on reset
    p_page_stable_r7: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> $stable(page_size));

    // R4: busy never lasts beyond the programmed duration
    p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!por_n)
        run_len <= RUN_W'(PROG_CYCLES));

endmodule

bind pgsz_cfg_decoder pgsz_cfg_decoder_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .busy      (prog_busy),
    .nv_flag   (otp_set),
    .cs_end    (sel_end),
    .page_size (page_size)
);

// File: tb/pgsz_cfg_decoder_tb.sv
`timescale 1ns/1ps
module pgsz_cfg_decoder_tb;

    localparam int unsigned PROG = 1000;
    localparam int unsigned NVEC = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] status_byte;
    logic [9:0] page_size;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pgsz_cfg_decoder #(.PROG_CYCLES(PROG)) u_dut (
        .clk         (clk),
        .por_n       (por_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .status_byte (status_byte),
        .page_size   (page_size)
    );

    // {expected status[7:0], byte count[3:0], trailing bits[3:0], b0..b4}
    localparam logic [55:0] VEC [NVEC] = '{
        {8'h80, 4'd4, 4'd0, 40'h3D2A80A700},   // R2 wrong last byte
        {8'h80, 4'd4, 4'd0, 40'h3C2A80A600},   // R2 wrong first byte
        {8'h80, 4'd4, 4'd0, 40'h3D2B80A600},   // R2 wrong second byte
        {8'h80, 4'd4, 4'd0, 40'h3D2A81A600},   // R2 wrong third byte
        {8'h80, 4'd4, 4'd0, 40'h2A3D80A600},   // R2 swapped order
        {8'h80, 4'd3, 4'd0, 40'h3D2A800000},   // R3 too short
        {8'h80, 4'd5, 4'd0, 40'h3D2A80A600},   // R3 extra byte
        {8'h80, 4'd4, 4'd3, 40'h3D2A80A6FF},   // R3 partial trailing byte
        {8'h80, 4'd4, 4'd0, 40'hBC540165_00},  // R1 bit-reversed bytes
        {8'h80, 4'd4, 4'd0, 40'hA6802A3D00}    // R2 reversed order
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_high();
        spi_cs_n = 1'b1;
        tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = b[7-i];
            tick(4);
            spi_sclk = 1'b1;
            tick(4);
            spi_sclk = 1'b0;
            tick(4);
        end
    endtask

    task automatic send_cfg_cmd();
        cs_low();
        send_bits(8'h3D, 8);
        send_bits(8'h2A, 8);
        send_bits(8'h80, 8);
        send_bits(8'hA6, 8);
    endtask

    task automatic read_status(output logic [7:0] r);
        cs_low();
        send_bits(8'hD7, 8);
        for (int i = 0; i < 8; i++) begin
            r[7-i] = spi_miso;
            spi_sclk = 1'b1;
            tick(4);
            spi_sclk = 1'b0;
            tick(4);
        end
        cs_high();
    endtask

    task automatic pulse_por();
        por_n = 1'b0;
        tick(4);
        por_n = 1'b1;
        tick(4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        tick(5);
        por_n = 1'b1;
        tick(4);

        // Reset state
        chk("R7 reset page size", 32'(page_size), 32'd528);
        chk("R8 reset status", 32'(status_byte), 32'h80);
        chk("R10 miso idle", 32'(spi_miso), 32'd0);

        read_status(rd);
        chk("R10 R1 status readback idle", 32'(rd), 32'h80);

        // Rejected command table
        for (int v = 0; v < NVEC; v++) begin
            logic [55:0] e;
            e = VEC[v];
            cs_low();
            for (int k = 0; k < int'(e[47:44]); k++)
                send_bits(e[39-8*k -: 8], 8);
            if (e[43:40] != 4'd0)
                send_bits(e[7:0], int'(e[43:40]));
            cs_high();
            tick(4);
            chk($sformatf("R2 R3 vector %0d status", v), 32'(status_byte), 32'(e[55:48]));
            chk($sformatf("R3 vector %0d page", v), 32'(page_size), 32'd528);
        end

        // Interrupted programming cycle
        send_cfg_cmd();
        spi_cs_n = 1'b1;
        tick(3);
        chk("R4 busy after release", 32'(status_byte), 32'h00);
        tick(8);
        read_status(rd);
        chk("R5 R10 status read while busy", 32'(rd), 32'h00);
        pulse_por();
        chk("R9 busy cleared by por", 32'(status_byte), 32'h80);
        tick(PROG + 20);
        chk("R9 flag still clear", 32'(status_byte), 32'h80);
        chk("R9 page after abort", 32'(page_size), 32'd528);

        // Full programming cycle with a command sent while busy
        send_cfg_cmd();
        spi_cs_n = 1'b1;
        tick(2);
        chk("R4 not busy before start", 32'(status_byte[7]), 32'd1);
        tick(1);
        chk("R4 busy at start", 32'(status_byte[7]), 32'd0);
        tick(20);
        send_cfg_cmd();
        cs_high();
        tick(PROG - 1 - 20 - 396);
        chk("R4 R5 still busy at last cycle", 32'(status_byte), 32'h00);
        tick(1);
        chk("R4 R5 R8 ready and configured on time", 32'(status_byte), 32'h81);
        chk("R7 page unchanged before por", 32'(page_size), 32'd528);
        tick(10);
        chk("R5 no restart from busy command", 32'(status_byte), 32'h81);

        pulse_por();
        chk("R7 page after por", 32'(page_size), 32'd512);
        chk("R6 R8 flag after por", 32'(status_byte), 32'h81);

        // Command after the flag is set
        send_cfg_cmd();
        spi_cs_n = 1'b1;
        tick(10);
        chk("R5 R6 command ignored once set", 32'(status_byte), 32'h81);
        read_status(rd);
        chk("R10 R8 status readback configured", 32'(rd), 32'h81);

        pulse_por();
        pulse_por();
        chk("R6 flag after repeated por", 32'(status_byte), 32'h81);
        chk("R7 page after repeated por", 32'(page_size), 32'd512);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule